// File: doc/BRIEF.md
# Task-File Status and Interrupt Unit

This block holds the device-side status byte of an ATA-style task-file interface. Single-cycle event pulses from the device core update eight flags: busy, ready, write fault, seek complete, data request, corrected data, index and error. The host reads those flags at two addresses. The primary status address clears any pending interrupt. The alternate status address returns the same byte and does not clear the interrupt. A device control register sits at the alternate address on writes. It holds an interrupt mask bit and a soft reset bit. The host can write it at any time.

The block also produces three outputs. The host interrupt line is the pending flag with the mask applied. The DMA request passes through only while the busy or data request flag is set. A write strobe for the command-block registers is issued only while the device is not busy.

There is no streaming data path, so every pin is a plain level or a single-cycle strobe. The host bus is a simple synchronous strobe interface with no back-pressure. Read data comes out combinationally from the address. Read side effects take effect at the clock edge on which `host_rd` is sampled high.

Top module: `tsu_top`

## Requirements
- R1: After reset the status byte reads 0x00 at both status addresses, and `irq`, `dmarq`, `srst_out` and `cmd_wr_en` are 0. The flag bit positions are busy=7, ready=6, write fault=5, seek complete=4, data request=3, corrected=2, index=1 and error=0. The index bit always reads 0.
- R2: An `ev_ready` pulse sets ready and seek complete. Ready stays 0 from reset until that pulse.
- R3: While busy is 1, a read at either status address returns 0x80. The other flags are hidden while busy is 1.
- R4: `ev_cmd_start` sets busy and clears error, write fault and corrected. `ev_cmd_done` clears busy and data request, and it sets error when `ev_cmd_err` is also 1. `ev_drq_on` and `ev_drq_off` set and clear data request, and on wins if both arrive together. `ev_wr_fault` sets write fault.
- R5: `ev_corrected` sets the corrected bit and leaves busy and data request unchanged.
- R6: The interrupt becomes pending on `ev_cmd_done` or `ev_drq_on`. A read at the primary status address (0x7) clears it. When a set and a clear fall in the same cycle, the interrupt stays pending.
- R7: A read at the alternate status address (0xE) returns the same byte as the primary address and leaves the pending interrupt in place.
- R8: Writing 1 to device control bit 1 (address 0xE) forces `irq` to 0 but keeps the interrupt pending. Writing 0 to that bit lets `irq` show the pending interrupt again.
- R9: Writing 1 to device control bit 2 raises `srst_out` one cycle later. From the following cycle the status byte is 0x80 and the pending interrupt is cleared. Core events are ignored while the bit is 1. Once the bit is written back to 0, busy returns to 0 and all other flags stay cleared.
- R10: Device control writes take effect even while busy is 1. A host write at addresses 0x0 to 0x7 raises `cmd_wr_en` only while busy is 0.
- R11: `dmarq` follows `core_dmarq` only while busy or data request is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Task-file register offset |
| host_rd | input | 1 | Host read strobe; drives the read side effects |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status byte at offsets 0x7 and 0xE; 0 elsewhere |
| cmd_wr_en | output | 1 | Command-block write forwarded to the command decoder |
| ev_cmd_start | input | 1 | Core has accepted a command |
| ev_cmd_done | input | 1 | Core has finished a command |
| ev_cmd_err | input | 1 | Qualifies ev_cmd_done as ending in error |
| ev_wr_fault | input | 1 | Core reports a write fault |
| ev_drq_on | input | 1 | Core wants a data transfer |
| ev_drq_off | input | 1 | Data transfer block finished |
| ev_corrected | input | 1 | Correctable error was fixed |
| ev_ready | input | 1 | Core can accept commands |
| core_dmarq | input | 1 | DMA request from the core |
| dmarq | output | 1 | Gated DMA request to the host |
| irq | output | 1 | Host interrupt request |
| srst_out | output | 1 | Soft reset level to the core |

## Verification
A wrong flag shows up in the status byte on the first alternate-address read after the edge that should have changed it. The alternate read is safe to repeat, so the bench reads through it after every event. A pending flag that is kept or lost wrongly shows on `irq` in the cycle after the event, the primary read or the mask change. A mask that drops the pending flag instead of hiding it shows only after the mask is cleared again. A busy flag stuck at 1 is visible at once: the status byte freezes at 0x80, `cmd_wr_en` stays low and `dmarq` passes through when it should be gated.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int SW     = 8;
  localparam int B_BSY  = 7;
  localparam int B_RDY  = 6;
  localparam int B_DWF  = 5;
  localparam int B_DSC  = 4;
  localparam int B_DRQ  = 3;
  localparam int B_CORR = 2;
  localparam int B_IDX  = 1;
  localparam int B_ERR  = 0;
  localparam logic [SW-1:0] BUSY_VIEW = 8'h80;

  typedef struct packed {
    logic cmd_start;
    logic cmd_done;
    logic cmd_err;
    logic wr_fault;
    logic drq_on;
    logic drq_off;
    logic corrected;
    logic ready;
  } core_ev_t;
endpackage

// File: rtl/tsu_flags.sv
module tsu_flags
  import tsu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  core_ev_t      ev,
  input  logic          srst,
  output logic [SW-1:0] flags
);
  logic [SW-1:0] nxt;
  logic          srst_d;

  always_comb begin
    nxt = flags;
    // leaving soft reset: drop busy, everything else already cleared
    if (srst_d) nxt[B_BSY] = 1'b0;
    if (ev.cmd_start) begin
      nxt[B_ERR]  = 1'b0;
      nxt[B_DWF]  = 1'b0;
      nxt[B_CORR] = 1'b0;
    end
    if (ev.cmd_done) begin
      nxt[B_BSY] = 1'b0;
      nxt[B_DRQ] = 1'b0;
      if (ev.cmd_err) nxt[B_ERR] = 1'b1;
    end
    if (ev.cmd_start) nxt[B_BSY]  = 1'b1;
    if (ev.drq_off)   nxt[B_DRQ]  = 1'b0;
    if (ev.drq_on)    nxt[B_DRQ]  = 1'b1;
    if (ev.wr_fault)  nxt[B_DWF]  = 1'b1;
    if (ev.corrected) nxt[B_CORR] = 1'b1;
    if (ev.ready) begin
      nxt[B_RDY] = 1'b1;
      nxt[B_DSC] = 1'b1;
    end
    nxt[B_IDX] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      srst_d <= 1'b0;
    end else begin
      srst_d <= srst;
      if (srst) flags <= BUSY_VIEW;
      else      flags <= nxt;
    end
  end

  // R9: soft reset forces busy-only status on the next cycle
  a_r9_srst_busy_only: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (flags == BUSY_VIEW));

  // R5: a corrected-data event leaves the transfer state alone
  a_r5_corr_keeps_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.corrected && !srst && !srst_d && !ev.cmd_start && !ev.cmd_done &&
     !ev.drq_on && !ev.drq_off)
    |=> ($stable(flags[B_BSY]) && $stable(flags[B_DRQ]) && flags[B_CORR]));

  // R2: ready is only raised by the core ready event
  a_r2_rdy_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[B_RDY] && !ev.ready) |=> !flags[B_RDY]);
endmodule

// File: rtl/tsu_irq.sv
module tsu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic mask,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (set_ev) pending <= 1'b1;
    else if (clr_ev) pending <= 1'b0;
  end

  assign irq = pending & ~mask;

  // R6: set beats clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> pending);

  // R6: a clear alone drops the pending flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !pending);

  // R8: masking never drops the pending flag
  a_r8_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && pending && !clr_ev) |=> pending);
endmodule

// File: rtl/tsu_host.sv
module tsu_host
  import tsu_pkg::*;
#(
  parameter int AW        = 4,
  parameter int STAT_ADDR = 7,
  parameter int ALT_ADDR  = 14,
  parameter int CB_LAST   = 7,
  parameter int NIEN_BIT  = 1,
  parameter int SRST_BIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [SW-1:0] host_wdata,
  input  logic [SW-1:0] flags,
  output logic [SW-1:0] host_rdata,
  output logic          cmd_wr_en,
  output logic          pri_read,
  output logic          nien,
  output logic          srst
);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
  localparam logic [AW-1:0] A_ALT  = AW'(ALT_ADDR);
  localparam logic [AW-1:0] A_CBL  = AW'(CB_LAST);

  logic          hit_stat, hit_alt, ctl_wr;
  logic [SW-1:0] view;

  assign hit_stat = (host_addr == A_STAT);
  assign hit_alt  = (host_addr == A_ALT);
  assign ctl_wr   = host_wr && hit_alt;
  assign pri_read = host_rd && hit_stat;
  assign view     = flags[B_BSY] ? BUSY_VIEW : flags;
  assign host_rdata = (hit_stat || hit_alt) ? view : '0;
  assign cmd_wr_en  = host_wr && (host_addr <= A_CBL) && !flags[B_BSY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nien <= 1'b0;
      srst <= 1'b0;
    end else if (ctl_wr) begin
      nien <= host_wdata[NIEN_BIT];
      srst <= host_wdata[SRST_BIT];
    end
  end

  // R3: busy hides every other flag at the port
  a_r3_busy_view: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[B_BSY] && (hit_stat || hit_alt)) |-> (host_rdata == BUSY_VIEW));

  // R10: control register write lands even while busy
  a_r10_ctl_always: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (nien == $past(host_wdata[NIEN_BIT])));

  // R7: both status addresses return one value (index bit low)
  a_r7_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_alt || hit_stat) |-> (host_rdata[B_IDX] == 1'b0));
endmodule

// File: rtl/tsu_top.sv
module tsu_top
  import tsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       cmd_wr_en,
  input  logic       ev_cmd_start,
  input  logic       ev_cmd_done,
  input  logic       ev_cmd_err,
  input  logic       ev_wr_fault,
  input  logic       ev_drq_on,
  input  logic       ev_drq_off,
  input  logic       ev_corrected,
  input  logic       ev_ready,
  input  logic       core_dmarq,
  output logic       dmarq,
  output logic       irq,
  output logic       srst_out
);
  core_ev_t      ev;
  logic [SW-1:0] flags;
  logic          pri_read, nien, srst, pending;

  assign ev = '{cmd_start: ev_cmd_start, cmd_done: ev_cmd_done,
                cmd_err: ev_cmd_err, wr_fault: ev_wr_fault,
                drq_on: ev_drq_on, drq_off: ev_drq_off,
                corrected: ev_corrected, ready: ev_ready};

  tsu_host #(.AW(4)) u_host (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .flags(flags),
    .host_rdata(host_rdata), .cmd_wr_en(cmd_wr_en), .pri_read(pri_read),
    .nien(nien), .srst(srst)
  );

  tsu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .srst(srst), .flags(flags)
  );

  tsu_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_ev((ev_cmd_done | ev_drq_on) & ~srst),
    .clr_ev(pri_read | srst),
    .mask(nien), .pending(pending), .irq(irq)
  );

  assign dmarq    = core_dmarq & (flags[B_BSY] | flags[B_DRQ]);
  assign srst_out = srst;

  // R11: no DMA request without busy or data request
  a_r11_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> (flags[B_BSY] || flags[B_DRQ]));

  // R10: command-block strobe never while busy
  a_r10_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |-> !flags[B_BSY]);

  // R9: soft reset holds the interrupt low one cycle on
  a_r9_srst_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && $past(srst)) |-> !pending);
endmodule

// File: tb/sim_tsu_top.sv
`timescale 1ns/1ps
module sim_tsu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       cmd_wr_en, dmarq, irq, srst_out;
  logic [7:0] ev = 8'h00;   // {start,done,err,wfault,drq_on,drq_off,corr,ready}
  logic       core_dmarq = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  tsu_top u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_wr_en(cmd_wr_en), .ev_cmd_start(ev[7]), .ev_cmd_done(ev[6]),
    .ev_cmd_err(ev[5]), .ev_wr_fault(ev[4]), .ev_drq_on(ev[3]),
    .ev_drq_off(ev[2]), .ev_corrected(ev[1]), .ev_ready(ev[0]),
    .core_dmarq(core_dmarq), .dmarq(dmarq), .irq(irq), .srst_out(srst_out)
  );

  // {events[7:0], pri_rd, alt_rd, exp_status[7:0], exp_irq, spare}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b0, 8'h50, 1'b0, 1'b0},  // R2 ready
    {8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0},  // R4 start, R3 masked
    {8'h08, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0},  // R6 drq sets pending
    {8'h00, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0},  // R6 primary read clears
    {8'h40, 1'b0, 1'b0, 8'h50, 1'b1, 1'b0},  // R4 done
    {8'h00, 1'b0, 1'b1, 8'h50, 1'b1, 1'b0},  // R7 alt read keeps
    {8'h02, 1'b0, 1'b0, 8'h54, 1'b1, 1'b0},  // R5 corrected
    {8'h00, 1'b1, 1'b0, 8'h54, 1'b0, 1'b0},  // R6 clear
    {8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0},  // R4 start clears corr
    {8'h70, 1'b0, 1'b0, 8'h71, 1'b1, 1'b0},  // R4 done+err+fault
    {8'h08, 1'b1, 1'b0, 8'h79, 1'b1, 1'b0},  // R6 set wins
    {8'h04, 1'b0, 1'b0, 8'h71, 1'b1, 1'b0}   // R4 drq off
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic alt_view();
    host_rd = 1'b0; host_wr = 1'b0; host_addr = 4'hE; ev = 8'h00;
  endtask

  task automatic ctl_write(input logic [7:0] d);
    host_addr = 4'hE; host_wr = 1'b1; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    ev = e;
    tick();
    ev = 8'h00;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    host_addr = 4'h7;   #0.5 chk("R1 primary status", host_rdata, 8'h00);
    host_addr = 4'hE;   #0.5 chk("R1 alt status", host_rdata, 8'h00);
    chk("R1 irq/dmarq/srst/cmd", {4'h0, irq, dmarq, srst_out, cmd_wr_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      ev = VEC[i][19:12];
      host_rd = VEC[i][11] | VEC[i][10];
      host_addr = VEC[i][11] ? 4'h7 : 4'hE;
      tick();
      alt_view();
      #0.5;
      chk($sformatf("R4/R6 vec%0d status", i), host_rdata, VEC[i][9:2]);
      chk($sformatf("R6/R7 vec%0d irq", i), {7'h0, irq}, {7'h0, VEC[i][1]});
      chk($sformatf("R1 vec%0d idx", i), {7'h0, host_rdata[1]}, 8'h00);
    end

    // R8 mask hides, pending kept
    ctl_write(8'h02);
    chk("R8 masked irq", {7'h0, irq}, 8'h00);
    chk("R8 status untouched", host_rdata, 8'h71);
    ctl_write(8'h00);
    chk("R8 unmasked pending kept", {7'h0, irq}, 8'h01);

    // R10 command strobe gating
    host_addr = 4'h3; host_wr = 1'b1; #0.5;
    chk("R10 cmd write idle", {7'h0, cmd_wr_en}, 8'h01);
    host_wr = 1'b0;
    pulse(8'h80);
    host_addr = 4'h3; host_wr = 1'b1; #0.5;
    chk("R10 cmd write busy ignored", {7'h0, cmd_wr_en}, 8'h00);
    host_wr = 1'b0;
    ctl_write(8'h02);
    chk("R10 ctl write while busy", {7'h0, irq}, 8'h00);
    ctl_write(8'h00);
    chk("R10 ctl unmask while busy", {7'h0, irq}, 8'h01);

    // R11 DMA gating (busy now 1, drq 0)
    core_dmarq = 1'b1; #0.5;
    chk("R11 dmarq with busy", {7'h0, dmarq}, 8'h01);
    pulse(8'h40);
    chk("R11 dmarq idle gated", {7'h0, dmarq}, 8'h00);
    pulse(8'h08);
    chk("R11 dmarq with drq", {7'h0, dmarq}, 8'h01);
    pulse(8'h04);
    core_dmarq = 1'b0;

    // R9 soft reset
    ctl_write(8'h04);
    chk("R9 srst_out", {7'h0, srst_out}, 8'h01);
    tick();
    alt_view(); #0.5;
    chk("R9 status busy only", host_rdata, 8'h80);
    chk("R9 pending cleared", {7'h0, irq}, 8'h00);
    pulse(8'h40);
    tick();
    chk("R9 events ignored irq", {7'h0, irq}, 8'h00);
    chk("R9 events ignored status", host_rdata, 8'h80);
    ctl_write(8'h00);
    tick();
    alt_view(); #0.5;
    chk("R9 release status", host_rdata, 8'h00);
    chk("R9 release srst_out", {7'h0, srst_out}, 8'h00);

    // R2 ready after soft reset
    pulse(8'h01);
    chk("R2 ready again", host_rdata, 8'h50);
    host_addr = 4'h7; #0.5;
    chk("R7 primary equals alt", host_rdata, 8'h50);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule